// File: doc/BRIEF.md
# Low-Order Interleaved Memory Controller

This block fronts a set of 2^K word-wide memory modules. The K least significant bits of each word address pick the module, and the remaining upper bits give the word inside it. A run of consecutive addresses therefore moves through the modules in turn. Each module stays busy for TC clocks after it accepts a command. The controller accepts one request per clock whenever the target module is free, so the slow module cycles overlap. A sequential stream keeps up one word per clock once the first read latency has passed.

Requests come in on a valid/ready channel. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the requester must keep its request stable. If it withdraws the request instead, that request has no effect. Read data goes back on a second valid/ready channel, strictly in the order the reads were accepted. A response waits until the clock edge where `rsp_ready` is high, and `rsp_rdata` holds still while it waits. Writes never produce a response. Each module keeps at most one unreturned read word. A small FIFO of module numbers sets the return order.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The module number is `req_addr[K-1:0]` and the in-module word is `req_addr[ADDR_W-1:K]`. A read returns the data last written to the same full address.
- R2: A module that accepts a command at clock edge t accepts no other command before edge t+TC. A request to it in that window sees `req_ready` low.
- R3: Requests to different free modules are accepted on consecutive edges. A stream of 2^K×4 sequential reads, or of 2^K×4 sequential writes, takes exactly one accept per clock when `rsp_ready` is high.
- R4: With `rsp_ready` high, a read accepted at edge t has `rsp_valid` high, carrying its data, in the cycle after edge t+TC-1.
- R5: Read responses leave in the same order as their requests were accepted, even when modules are hit out of order.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` is unchanged. A module whose read word has not been returned accepts no new request.
- R7: An accepted write changes the stored word and produces no response.
- R8: After reset, `rsp_valid` is low and `req_ready` is high for any address.
- R9: A request presented while `req_ready` is low and then withdrawn has no effect. A write offered this way leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low K bits select the module |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response this cycle |
| rsp_rdata | output | DATA_W | Read data |

## Verification
Two things can happen in the same cycle: a module hands back its held read word, and a new request to that same module is accepted. The ready path lets the module take the new command on the very edge its old word leaves. A sequential read stream with `rsp_ready` held high causes this on every clock. The stream is judged correct when the accept edges of 16 reads are exactly 15 clocks apart and every returned word matches, in order. The opposite case is provoked by dropping `rsp_ready` while a word is held. A request to that module must then see `req_ready` low, and a request to another module must still be accepted.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } ilv_cmd_e;
endpackage

// File: rtl/ilv_bank.sv
// One memory module: busy for TC clocks per command, holds one read word
module ilv_bank #(
  parameter int WW     = 6,
  parameter int DATA_W = 16,
  parameter int TC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [WW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic              rdy,
  output logic              held,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH   = 1 << WW;
  localparam int CW      = $clog2(TC + 1);
  localparam bit ONE_CYC = (TC == 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic              rd_pend;
  logic [WW-1:0]     addr_q;
  logic              finish;

  assign rdy    = (cnt == '0) && (!held || pop);
  assign finish = !sel && (cnt == CW'(1)) && rd_pend;

  always_ff @(posedge clk) begin
    if (sel && we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (sel) addr_q <= waddr;
  end

  always_ff @(posedge clk) begin
    if (ONE_CYC && sel && !we) rd_data <= mem[waddr];
    else if (finish)           rd_data <= mem[addr_q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      held    <= 1'b0;
      rd_pend <= 1'b0;
    end else begin
      if (pop) held <= 1'b0;
      if (sel) begin
        cnt     <= CW'(TC - 1);
        rd_pend <= !we;
        if (ONE_CYC && !we) held <= 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (finish) held <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilv_tag_fifo.sv
// Order FIFO of module numbers for outstanding reads
module ilv_tag_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_tag,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_p, rd_p;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head  = slots[rd_p];
  assign empty = (count == '0);
  assign full  = (count == CNW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) slots[wr_p] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push) wr_p <= bump(wr_p);
      if (pop)  rd_p <= bump(rd_p);
      if (push && !pop)      count <= count + CNW'(1);
      else if (pop && !push) count <= count - CNW'(1);
    end
  end
endmodule

// File: rtl/ilv_route.sv
// Address split and issue decision
module ilv_route
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int K      = 2
) (
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [(1<<K)-1:0]   bank_rdy,
  input  logic                tag_room,
  output logic                req_ready,
  output logic [(1<<K)-1:0]   sel,
  output logic [ADDR_W-K-1:0] word,
  output logic [K-1:0]        mod,
  output logic                tag_push
);
  localparam int NMOD = 1 << K;

  logic fire;

  assign mod       = req_addr[K-1:0];
  assign word      = req_addr[ADDR_W-1:K];
  assign req_ready = bank_rdy[mod] && (ilv_cmd_e'(req_we) == CMD_WR || tag_room);
  assign fire      = req_valid && req_ready;
  assign tag_push  = fire && (ilv_cmd_e'(req_we) == CMD_RD);

  for (genvar m = 0; m < NMOD; m++) begin : g_sel
    assign sel[m] = fire && (mod == K'(m));
  end
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int K      = 2,
  parameter int TC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int NMOD   = 1 << K;
  localparam int WW     = ADDR_W - K;
  localparam int TCNT_W = $clog2(NMOD + 1);

  logic [NMOD-1:0]   bank_sel, bank_rdy, bank_held, bank_pop;
  logic [DATA_W-1:0] bank_data [NMOD];
  logic [WW-1:0]     word;
  logic [K-1:0]      mod;
  logic              tag_push, tag_pop, tag_empty, tag_full;
  logic [K-1:0]      tag_head;
  logic [TCNT_W-1:0] tag_cnt;

  ilv_route #(.ADDR_W(ADDR_W), .K(K)) u_route (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .bank_rdy  (bank_rdy),
    .tag_room  (!tag_full || tag_pop),
    .req_ready (req_ready),
    .sel       (bank_sel),
    .word      (word),
    .mod       (mod),
    .tag_push  (tag_push)
  );

  ilv_tag_fifo #(.DEPTH(NMOD), .W(K)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (tag_push),
    .push_tag (mod),
    .pop      (tag_pop),
    .head     (tag_head),
    .empty    (tag_empty),
    .full     (tag_full),
    .count    (tag_cnt)
  );

  assign rsp_valid = !tag_empty && bank_held[tag_head];
  assign rsp_rdata = bank_data[tag_head];
  assign tag_pop   = rsp_valid && rsp_ready;

  for (genvar m = 0; m < NMOD; m++) begin : g_bank
    assign bank_pop[m] = tag_pop && (tag_head == K'(m));
    ilv_bank #(.WW(WW), .DATA_W(DATA_W), .TC(TC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (bank_sel[m]),
      .we      (req_we),
      .waddr   (word),
      .wdata   (req_wdata),
      .pop     (bank_pop[m]),
      .rdy     (bank_rdy[m]),
      .held    (bank_held[m]),
      .rd_data (bank_data[m])
    );
  end
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
  parameter int NMOD   = 4,
  parameter int TC     = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NMOD-1:0]   bank_sel,
  input logic [NMOD-1:0]   bank_rdy,
  input logic [CNT_W-1:0]  tag_cnt
);
  // R8: first cycle out of reset is quiet and open
  a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!rsp_valid && req_ready));

  // R6: a stalled response holds
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R3: at most one module issues per clock
  a_r3_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  // R5: outstanding reads never exceed the module count
  a_r5_tag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tag_cnt <= CNT_W'(NMOD));

  // R2: a module that just took a command is busy next cycle
  if (TC > 1) begin : g_busy
    for (genvar m = 0; m < NMOD; m++) begin : g_m
      a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel[m] |=> !bank_rdy[m]);
    end
  end
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
  .NMOD(NMOD), .TC(TC), .DATA_W(DATA_W), .CNT_W(TCNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .bank_sel  (bank_sel),
  .bank_rdy  (bank_rdy),
  .tag_cnt   (tag_cnt)
);

// File: tb/ilv_mem_ctrl_bench.sv
module ilv_mem_ctrl_bench;
  localparam int TC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;

  ilv_mem_ctrl u_ilv_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit lat_chk = 1'b1;
  bit done = 1'b0;
  int exp_q[$];
  int acc_q[$];

  typedef struct packed { logic we; logic [7:0] addr; logic [15:0] dat; } vec_t;
  // reads carry the expected word in dat
  localparam vec_t TBL [14] = '{
    '{1'b1, 8'h00, 16'h1111}, '{1'b1, 8'h01, 16'h2222},
    '{1'b1, 8'h02, 16'h3333}, '{1'b1, 8'h03, 16'h4444},
    '{1'b1, 8'h04, 16'h5555}, '{1'b1, 8'h09, 16'h6666},
    '{1'b0, 8'h02, 16'h3333}, '{1'b0, 8'h04, 16'h5555},
    '{1'b0, 8'h00, 16'h1111}, '{1'b1, 8'h02, 16'h7777},
    '{1'b0, 8'h02, 16'h7777}, '{1'b0, 8'h09, 16'h6666},
    '{1'b0, 8'h01, 16'h2222}, '{1'b0, 8'h03, 16'h4444}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [7:0] a, input logic [15:0] d,
                       output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc = cyc;
    if (!we) begin exp_q.push_back(int'(d)); acc_q.push_back(cyc); end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic drain;
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R5 drain", exp_q.size(), 0);
  endtask

  // response monitor: R1 data, R5 order, R4 latency, R7 no write responses
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected response", int'(rsp_rdata), 0);
      end else begin
        check(int'(rsp_rdata) == exp_q[0], "R1/R5 read data in order",
              int'(rsp_rdata), exp_q[0]);
        if (lat_chk)
          check(cyc - acc_q[0] == TC, "R4 read latency", cyc - acc_q[0], TC);
        void'(exp_q.pop_front());
        void'(acc_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, a1, first, last;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R8 no response after reset", rsp_valid, 0);

    // table walk: mixed modules, conflicts, overwrite
    foreach (TBL[i]) issue(TBL[i].we, TBL[i].addr, TBL[i].dat, a0);
    drain();

    // R3 sequential writes then reads, one per clock
    first = 0; last = 0;
    for (int i = 0; i < 16; i++) begin
      issue(1'b1, 8'h40 + 8'(i), 16'hA000 + 16'(i), a0);
      if (i == 0) first = a0;
      last = a0;
    end
    check(last - first == 15, "R3 write stream rate", last - first, 15);
    repeat (TC + 2) @(negedge clk);
    #2 check(rsp_valid == 1'b0, "R7 writes give no response", rsp_valid, 0);
    for (int i = 0; i < 16; i++) begin
      issue(1'b0, 8'h40 + 8'(i), 16'hA000 + 16'(i), a0);
      if (i == 0) first = a0;
      last = a0;
    end
    check(last - first == 15, "R3 read stream rate", last - first, 15);
    drain();

    // R2 same-module spacing
    issue(1'b1, 8'h8C, 16'h1234, a0);
    repeat (TC) @(negedge clk);
    issue(1'b1, 8'h80, 16'h0BAD, a0);
    issue(1'b1, 8'h84, 16'h0C0D, a1);
    check(a1 - a0 == TC, "R2 busy spacing", a1 - a0, TC);
    // R9 withdrawn write to busy module
    issue(1'b1, 8'h88, 16'h0E0E, a0);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 8'h8C; req_wdata = 16'hDEAD;
    #1 check(req_ready == 1'b0, "R2 busy module stalls", req_ready, 0);
    @(posedge clk); #1 req_valid = 1'b0;
    issue(1'b0, 8'h8C, 16'h1234, a0);
    issue(1'b0, 8'h84, 16'h0C0D, a0);
    drain();

    // R6 response back-pressure
    lat_chk = 1'b0;
    @(negedge clk); rsp_ready = 1'b0;
    issue(1'b0, 8'h40, 16'hA000, a0);
    repeat (TC) @(negedge clk);
    #2 check(rsp_valid == 1'b1, "R6 response waiting", rsp_valid, 1);
    check(rsp_rdata == 16'hA000, "R6 response data", int'(rsp_rdata), 16'hA000);
    repeat (2) @(negedge clk);
    #2 check(rsp_valid == 1'b1 && rsp_rdata == 16'hA000, "R6 response held",
             int'(rsp_rdata), 16'hA000);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 8'h44;
    #1 check(req_ready == 1'b0, "R6 holding module blocks", req_ready, 0);
    @(posedge clk); #1 req_valid = 1'b0;
    issue(1'b0, 8'h41, 16'hA001, a0);
    check(1'b1, "R6 free module accepted", 1, 1);
    repeat (TC + 1) @(negedge clk);
    rsp_ready = 1'b1;
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule